// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Router

This block sits next to a FIFO-based serial port. It takes six status flags from the port and turns them into requests. There are three vector-level interrupt lines for the CPU and two DMA request lines, one for transmit and one for receive. Each flag is qualified by its own enable bit. A mode input selects clock-synchronous or asynchronous operation. In clock-synchronous mode only the transmit-empty and receive-full sources stay live.

The six sources fold pairwise onto three vectors, and every vector reports a one-bit source identifier. The transmit pair (empty, stopped) and the receive-full source can be steered to DMA through a per-channel DMA-mode input. A steered source raises a DMA request and never a CPU interrupt. Each DMA channel runs a small state machine with three states:

- `DMA_IDLE`: waiting for a live steered source. IDLE→REQ when one exists.
- `DMA_REQ`: the request line is high. REQ→GAP on acknowledge.
- `DMA_GAP`: a forced low cycle. GAP→IDLE unconditionally.

Top module: `sio_irq_router`

## Requirements
- R1: While `rst_n` is low, every `irq`, `irq_id` and `dma_req` bit is 0.
- R2: Source bits are: 0 tx-empty, 1 tx-stopped, 2 rx-error, 3 break, 4 rx-full, 5 rx-ready. Vector v (irq[v]) carries sources 2v and 2v+1. irq[v] goes high one clock edge after an enabled flag of its pair is sampled high.
- R3: A flag whose enable bit is 0 raises neither an interrupt nor a DMA request.
- R4: With `sync_mode`=1, sources 1, 2, 3 and 5 are treated as inactive for both interrupts and DMA.
- R5: irq_id[v] is 0 when source 2v is pending (alone or with 2v+1). It is 1 when only source 2v+1 is pending. It is 0 when nothing is pending.
- R6: irq[v] and irq_id[v] return to 0 one clock edge after the flags or enables of vector v clear.
- R7: With dma_mode[0]=1, sources 0 and 1 never reach irq[0]. With dma_mode[1]=1, source 4 never reaches irq[2]. A steered source still needs its enable bit to request DMA.
- R8: dma_req[0] rises one edge after an enabled, live source 0 or 1 is sampled while dma_mode[0]=1.
- R9: dma_req[1] is raised only by source 4. Source 5 never raises it.
- R10: A raised dma_req[c] holds until dma_ack[c] is sampled high. It then reads 0 for exactly two cycles, and rises again on the next edge if its source is still live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| flags | input | 6 | Status flags, one bit per source |
| enables | input | 6 | Per-source enable bits |
| dma_mode | input | 2 | Steer channel to DMA: bit0 transmit pair, bit1 receive-full |
| dma_ack | input | 2 | DMA acknowledge per channel |
| irq | output | 3 | Vector-level interrupt lines |
| irq_id | output | 3 | Pending-source identifier per vector |
| dma_req | output | 2 | DMA request: bit0 transmit, bit1 receive |

## Verification
The acknowledge of a DMA request can arrive in the same cycle that its source is still live. The request must then drop and go through the gap before it asserts again, and must not stay high. The bench holds the transmit-empty flag high while it pulses the acknowledge. It then expects two low cycles followed by a re-assertion. Interrupt traffic on an unrelated vector runs in the same cycles, and its lines must stay unaffected.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int NUM_VEC = NUM_SRC / 2;
    localparam int NUM_DMA = 2;

    // sources still live in clock-synchronous mode: tx-empty and rx-full
    localparam logic [NUM_SRC-1:0] SYNC_KEEP = 6'b010001;

    // sources each DMA channel may take over
    localparam logic [NUM_SRC-1:0] DMA_TX_MASK = 6'b000011;
    localparam logic [NUM_SRC-1:0] DMA_RX_MASK = 6'b010000;

    typedef enum logic [1:0] {
        DMA_IDLE = 2'd0,
        DMA_REQ  = 2'd1,
        DMA_GAP  = 2'd2
    } dma_state_t;
endpackage

// File: rtl/sio_src_gate.sv
module sio_src_gate
    import sio_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] enables,
    input  logic               sync_mode,
    input  logic [NUM_DMA-1:0] dma_mode,
    output logic [NUM_SRC-1:0] cpu_src,
    output logic [NUM_DMA-1:0] dma_want
);
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] chan_mask [NUM_DMA];
    logic [NUM_SRC-1:0] to_dma;

    assign chan_mask[0] = DMA_TX_MASK;
    assign chan_mask[1] = DMA_RX_MASK;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
        assign live[i] = flags[i] & enables[i] & (~sync_mode | SYNC_KEEP[i]);
    end

    always_comb begin
        to_dma = '0;
        for (int c = 0; c < NUM_DMA; c++) begin
            if (dma_mode[c]) begin
                to_dma = to_dma | chan_mask[c];
            end
        end
    end

    for (genvar c = 0; c < NUM_DMA; c++) begin : g_want
        assign dma_want[c] = dma_mode[c] & (|(live & chan_mask[c]));
    end

    assign cpu_src = live & ~to_dma;
endmodule

// File: rtl/sio_vec_merge.sv
module sio_vec_merge
    import sio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cpu_src,
    output logic [NUM_VEC-1:0] irq,
    output logic [NUM_VEC-1:0] irq_id
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq[v]    <= 1'b0;
                irq_id[v] <= 1'b0;
            end else begin
                irq[v]    <= cpu_src[2*v] | cpu_src[2*v+1];
                irq_id[v] <= ~cpu_src[2*v] & cpu_src[2*v+1];
            end
        end
    end
endmodule

// File: rtl/sio_dma_chan.sv
module sio_dma_chan
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic ack,
    output logic req
);
    dma_state_t state_q;
    dma_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE: if (want) state_d = DMA_REQ;
            DMA_REQ:  if (ack)  state_d = DMA_GAP;
            DMA_GAP:            state_d = DMA_IDLE;
            default:            state_d = DMA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req = (state_q == DMA_REQ);
    end
endmodule

// File: rtl/sio_irq_router.sv
module sio_irq_router
    import sio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_mode,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] enables,
    input  logic [NUM_DMA-1:0] dma_mode,
    input  logic [NUM_DMA-1:0] dma_ack,
    output logic [NUM_VEC-1:0] irq,
    output logic [NUM_VEC-1:0] irq_id,
    output logic [NUM_DMA-1:0] dma_req
);
    logic [NUM_SRC-1:0] cpu_src;
    logic [NUM_DMA-1:0] dma_want;

    sio_src_gate u_gate (
        .flags    (flags),
        .enables  (enables),
        .sync_mode(sync_mode),
        .dma_mode (dma_mode),
        .cpu_src  (cpu_src),
        .dma_want (dma_want)
    );

    sio_vec_merge u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_src(cpu_src),
        .irq    (irq),
        .irq_id (irq_id)
    );

    for (genvar c = 0; c < NUM_DMA; c++) begin : g_dma
        sio_dma_chan u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .want (dma_want[c]),
            .ack  (dma_ack[c]),
            .req  (dma_req[c])
        );
    end
endmodule

// File: rtl/sio_irq_router_chk.sv
module sio_irq_router_chk
    import sio_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sync_mode,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] enables,
    input logic [NUM_DMA-1:0] dma_mode,
    input logic [NUM_DMA-1:0] dma_ack,
    input logic [NUM_VEC-1:0] irq,
    input logic [NUM_VEC-1:0] irq_id,
    input logic [NUM_DMA-1:0] dma_req
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && irq_id == '0 && dma_req == '0));

    assert_gated_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past((flags & enables) == '0) |-> (irq == '0));

    assert_sync_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_mode) |-> (!irq[1] && !irq_id[0] && !irq_id[2]));

    assert_tx_no_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dma_mode[0]) |-> !irq[0]);

    for (genvar c = 0; c < NUM_DMA; c++) begin : g_dma_chk
        assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[c] && !dma_ack[c]) |=> dma_req[c]);

        assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[c] && dma_ack[c]) |=> !dma_req[c]);
    end
endmodule

bind sio_irq_router sio_irq_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_mode(sync_mode),
    .flags    (flags),
    .enables  (enables),
    .dma_mode (dma_mode),
    .dma_ack  (dma_ack),
    .irq      (irq),
    .irq_id   (irq_id),
    .dma_req  (dma_req)
);

// File: tb/sio_irq_router_bench.sv
`timescale 1ns/1ps
module sio_irq_router_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic [5:0] flags = '0;
    logic [5:0] enables = '0;
    logic [1:0] dma_mode = '0;
    logic [1:0] dma_ack = '0;
    logic [2:0] irq;
    logic [2:0] irq_id;
    logic [1:0] dma_req;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    // bench model of the DMA channel state: 0 idle, 1 requesting, 2 gap
    int mstate [2] = '{0, 0};

    always #2.5 clk = ~clk;

    sio_irq_router u_sio_irq_router (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .flags(flags),
        .enables(enables), .dma_mode(dma_mode), .dma_ack(dma_ack),
        .irq(irq), .irq_id(irq_id), .dma_req(dma_req)
    );

    task automatic step(input logic [5:0] f, input logic [5:0] e, input logic sm,
                        input logic [1:0] dm, input logic [1:0] ak, input string tag);
        logic [5:0] live, cpu;
        logic [2:0] xi, xd;
        logic [1:0] want, xr;
        @(negedge clk);
        flags = f; enables = e; sync_mode = sm; dma_mode = dm; dma_ack = ak;
        for (int i = 0; i < 6; i++) begin
            live[i] = f[i] & e[i] & (!sm || i == 0 || i == 4);
            cpu[i]  = live[i] & !(dm[0] && i < 2) & !(dm[1] && i == 4);
        end
        for (int v = 0; v < 3; v++) begin
            xi[v] = cpu[2*v] | cpu[2*v+1];
            xd[v] = !cpu[2*v] & cpu[2*v+1];
        end
        want[0] = dm[0] & (live[0] | live[1]);
        want[1] = dm[1] & live[4];
        for (int c = 0; c < 2; c++) begin
            if (mstate[c] == 1) mstate[c] = ak[c] ? 2 : 1;
            else if (mstate[c] == 2) mstate[c] = 0;
            else mstate[c] = want[c] ? 1 : 0;
            xr[c] = (mstate[c] == 1);
        end
        exp_q.push_back({xi, xd, xr});
        tag_q.push_back(tag);
    endtask

    // monitor: compares one expected item per clock, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if ({irq, irq_id, dma_req} !== e) begin
                    mismatched++;
                    $display("FAIL %s: irq/id/dma actual %b/%b/%b expected %b/%b/%b",
                             t, irq, irq_id, dma_req, e[7:5], e[4:2], e[1:0]);
                end
            end
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet under reset even with every source live
        flags = '1; enables = '1; dma_mode = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        compared++;
        if ({irq, irq_id, dma_req} !== 8'd0) begin
            mismatched++;
            $display("FAIL R1: actual %b expected 0", {irq, irq_id, dma_req});
        end
        @(negedge clk);
        flags = '0; enables = '0; dma_mode = '0;
        rst_n = 1'b1;

        step(6'b000000, 6'h3f, 0, 2'b00, 2'b00, "R1 idle");
        step(6'b000001, 6'h3f, 0, 2'b00, 2'b00, "R2 tx empty");
        step(6'b000010, 6'h3f, 0, 2'b00, 2'b00, "R5 tx stop only");
        step(6'b000011, 6'h3f, 0, 2'b00, 2'b00, "R5 pair pending");
        step(6'b111111, 6'h00, 0, 2'b00, 2'b00, "R3 all disabled");
        step(6'b111111, 6'h3f, 0, 2'b00, 2'b00, "R2 all vectors");
        step(6'b000000, 6'h3f, 0, 2'b00, 2'b00, "R6 flags clear");
        step(6'b101000, 6'h3f, 0, 2'b00, 2'b00, "R5 upper sources");
        step(6'b101000, 6'h00, 0, 2'b00, 2'b00, "R6 enables clear");
        step(6'b111111, 6'h3f, 1, 2'b00, 2'b00, "R4 sync all");
        step(6'b101110, 6'h3f, 1, 2'b00, 2'b00, "R4 sync forced off");
        step(6'b000101, 6'h3f, 0, 2'b01, 2'b00, "R7 R8 tx to dma");
        step(6'b000101, 6'h3f, 0, 2'b01, 2'b00, "R10 hold");
        step(6'b000101, 6'h3f, 0, 2'b01, 2'b01, "R10 ack while live");
        step(6'b000101, 6'h3f, 0, 2'b01, 2'b00, "R10 gap");
        step(6'b000101, 6'h3f, 0, 2'b01, 2'b00, "R10 reassert");
        step(6'b110000, 6'h3f, 0, 2'b10, 2'b01, "R9 rx full to dma");
        step(6'b100000, 6'h3f, 0, 2'b10, 2'b10, "R9 ack rx");
        step(6'b100000, 6'h3f, 0, 2'b10, 2'b00, "R9 gap");
        step(6'b100000, 6'h3f, 0, 2'b10, 2'b00, "R9 rx ready no dma");
        step(6'b000001, 6'h3e, 0, 2'b01, 2'b00, "R7 enable needed");
        step(6'b000010, 6'h3f, 1, 2'b01, 2'b00, "R4 sync tx stop no dma");
        step(6'b000000, 6'h00, 0, 2'b00, 2'b00, "R6 final");

        repeat (3) @(posedge clk);
        #2;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule